// File: doc/BRIEF.md
# I2C EEPROM Target with Upper-Half Write Protection

This block is an I2C target that behaves like a small serial EEPROM. The storage is an on-chip register array of 256 or 512 bytes, chosen by a parameter and split into 16-byte pages. A controller first sends a word address and then one or more data bytes. The data bytes are held in a page buffer. On STOP they are copied into the array in a single step, and a timed write cycle follows. During that cycle the target ignores its own address, so the controller can poll it for an acknowledge. Reads send bytes out from an internal address counter, which advances after every byte. A write-protect input guards the upper half of the array. The target never drives SDA high. It only pulls SDA low through `sda_oe_o`, and it only watches SCL.

Protocol states: `S_IDLE` waits for START. `S_DEV` shifts in the device byte. If the address matches and no write cycle is running, it moves to `S_DACK`. Otherwise it returns to `S_IDLE`. From `S_DACK`, a write goes to `S_WORD` and a read goes to `S_RDAT`. `S_WORD` moves to `S_WACKA` and then to `S_WDAT`. `S_WDAT` and `S_WACK` alternate, one pass per data byte. `S_RDAT` moves to `S_RACK`. In `S_RACK`, an acknowledge from the controller leads back to `S_RDAT`, and a NACK leads to `S_IDLE`. A START in any state leads to `S_DEV`. A STOP in any state leads to `S_IDLE`.

Top module: `i2c_eeprom_wp`

## Requirements
- R1: After reset, SDA is released, `busy_o` is low, every array byte reads 0x00 and the address counter is 0.
- R2: With 256 bytes, the target acknowledges the 7-bit address 1010 followed by `sel_i[2:0]`. For any other address it never pulls SDA low until the next START.
- R3: With 512 bytes, the address is 1010, `sel_i[2]`, `sel_i[1]`, B. `sel_i[0]` is ignored. For a write-direction device byte, B becomes address bit 8.
- R4: Data bytes go into the page buffer, and STOP commits all of them to the array together. A START that arrives before STOP discards the buffered bytes and does not start a write cycle.
- R5: During a write, the low 4 address bits wrap from 15 to 0. Extra bytes therefore overwrite earlier bytes of the same page, and other pages stay untouched.
- R6: A commit raises `busy_o` for WRITE_CYCLES clocks. While `busy_o` is high, the target does not acknowledge its own address. Once the cycle ends, it acknowledges again.
- R7: If `wp_i` is high at STOP and the page lies in the upper half (top address bit 1), the array is left unchanged. The data bytes are still acknowledged, and pages in the lower half are written as usual.
- R8: A device byte in the write direction, then a word address, then a repeated START with a read-direction device byte, returns data from that word address.
- R9: Sequential reads return consecutive addresses, and the address wraps from the last array byte to 0.
- R10: A read-direction device byte with no word address first starts at the address that follows the last byte accessed.
- R11: After a NACK from the controller, the target releases SDA and stays idle until the next START.
- R12: Behaviour does not depend on the SCL period, as long as each SCL level lasts at least 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open drain) |
| sel_i | input | 3 | Address-select straps |
| wp_i | input | 1 | Write protect for the upper half |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The bench places two instances on one shared bus. One has 256 bytes with select straps 000. The other has 512 bytes with straps 011. With both present, the bench can check that a target ignores bytes addressed to its neighbour. It can also check that the block bit of the larger device selects between two distinct 256-byte halves, and that the lowest strap has no effect there. WRITE_CYCLES is reduced to 1000. The first acknowledge poll after a commit therefore lands inside the write cycle, while the whole run still stays short. Most transfers use a quarter-bit of 10 clocks. One transfer uses 40 clocks, to exercise R12.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DACK,
        S_WORD,
        S_WACKA,
        S_WDAT,
        S_WACK,
        S_RDAT,
        S_RACK
    } bus_state_t;

    localparam int         PAGE_BYTES = 16;
    localparam int         OFS_W      = $clog2(PAGE_BYTES);
    localparam logic [3:0] DEV_TYPE   = 4'b1010;
endpackage

// File: rtl/eep_bus_sense.sv
`timescale 1ns/1ps
module eep_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_p, sda_p;
    logic       scl_s, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_p    <= scl_sync[1];
            sda_p    <= sda_sync[1];
        end
    end

    assign scl_s      = scl_sync[1];
    assign sda_s      = sda_sync[1];
    assign scl_rise_o = scl_s & ~scl_p;
    assign scl_fall_o = ~scl_s & scl_p;
    assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
    assign sda_o      = sda_s;
endmodule

// File: rtl/eep_page_buf.sv
`timescale 1ns/1ps
module eep_page_buf #(
    parameter int SLOTS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     wr_i,
    input  logic [$clog2(SLOTS)-1:0] idx_i,
    input  logic [7:0]               data_i,
    output logic [SLOTS*8-1:0]       data_o,
    output logic [SLOTS-1:0]         mask_o,
    output logic                     any_o
);
    localparam int IW = $clog2(SLOTS);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_o[s]         <= 1'b0;
                data_o[s*8 +: 8]  <= 8'h00;
            end else if (clr_i) begin
                mask_o[s]         <= 1'b0;
            end else if (wr_i && idx_i == IW'(s)) begin
                mask_o[s]         <= 1'b1;
                data_o[s*8 +: 8]  <= data_i;
            end
        end
    end

    assign any_o = |mask_o;
endmodule

// File: rtl/eep_array.sv
`timescale 1ns/1ps
module eep_array import eep_pkg::*; #(
    parameter int BYTES = 256,
    localparam int AW   = $clog2(BYTES),
    localparam int PW   = AW - OFS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [PW-1:0]           page_i,
    input  logic                    wp_i,
    input  logic [PAGE_BYTES*8-1:0] wdata_i,
    input  logic [PAGE_BYTES-1:0]   wmask_i,
    input  logic [AW-1:0]           raddr_i,
    output logic [7:0]              rdata_o
);
    logic [7:0] mem_q [BYTES];
    logic       blocked;

    assign blocked = wp_i & page_i[PW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= 8'h00;
        end else if (commit_i && !blocked) begin
            for (int k = 0; k < PAGE_BYTES; k++) begin
                if (wmask_i[k]) mem_q[{page_i, OFS_W'(k)}] <= wdata_i[k*8 +: 8];
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R7: a protected upper-half page keeps its contents through a commit
    p_protect_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && wp_i && page_i[PW-1]) |=>
        (mem_q[{$past(page_i), OFS_W'(0)}] == $past(mem_q[{page_i, OFS_W'(0)}])));
endmodule

// File: rtl/eep_wcycle.sv
`timescale 1ns/1ps
module eep_wcycle #(
    parameter int CYCLES = 1000000,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              left_q <= '0;
        else if (start_i)        left_q <= CW'(CYCLES);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign busy_o = (left_q != '0);

    // R6: each commit opens a write cycle
    p_busy_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
endmodule

// File: rtl/i2c_eeprom_wp.sv
`timescale 1ns/1ps
module i2c_eeprom_wp import eep_pkg::*; #(
    parameter int MEM_BYTES    = 256,
    parameter int WRITE_CYCLES = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] sel_i,
    input  logic       wp_i,
    output logic       busy_o
);
    localparam int AW        = $clog2(MEM_BYTES);
    localparam int PW        = AW - OFS_W;
    localparam bit BLOCK_BIT = (MEM_BYTES > 256);

    bus_state_t st_q, st_d;
    logic [3:0]    cnt_q;
    logic [7:0]    rx_q, tx_q;
    logic [AW-1:0] addr_q;
    logic          rw_q, sda_oe_q;

    logic scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic byte_done, dev_hit;
    logic [AW-1:0] addr_devw, addr_word;
    logic          buf_wr, buf_clr, buf_any, commit;
    logic [PAGE_BYTES*8-1:0] buf_data;
    logic [PAGE_BYTES-1:0]   buf_mask;
    logic [7:0]    rd_byte;

    eep_bus_sense u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .sda_o      (sda_bit)
    );

    assign byte_done = (cnt_q == 4'd8);

    if (BLOCK_BIT) begin : g_blk
        assign dev_hit   = (rx_q[7:4] == DEV_TYPE) && (rx_q[3:2] == sel_i[2:1]);
        assign addr_devw = {rx_q[1], addr_q[AW-2:0]};
        assign addr_word = {addr_q[AW-1], rx_q};
    end else begin : g_flat
        assign dev_hit   = (rx_q[7:4] == DEV_TYPE) && (rx_q[3:1] == sel_i);
        assign addr_devw = addr_q;
        assign addr_word = rx_q;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (start_det)      st_d = S_DEV;
        else if (stop_det)  st_d = S_IDLE;
        else begin
            unique case (st_q)
                S_IDLE:  st_d = S_IDLE;
                S_DEV:   if (scl_fall && byte_done) st_d = (dev_hit && !busy_o) ? S_DACK : S_IDLE;
                S_DACK:  if (scl_fall) st_d = rw_q ? S_RDAT : S_WORD;
                S_WORD:  if (scl_fall && byte_done) st_d = S_WACKA;
                S_WACKA: if (scl_fall) st_d = S_WDAT;
                S_WDAT:  if (scl_fall && byte_done) st_d = S_WACK;
                S_WACK:  if (scl_fall) st_d = S_WDAT;
                S_RDAT:  if (scl_fall && byte_done) st_d = S_RACK;
                S_RACK:  begin
                    if (scl_rise && sda_bit) st_d = S_IDLE;
                    else if (scl_fall)       st_d = S_RDAT;
                end
                default: st_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            addr_q   <= '0;
            rw_q     <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (start_det) begin
            cnt_q    <= '0;
            sda_oe_q <= 1'b0;
        end else if (stop_det) begin
            sda_oe_q <= 1'b0;
        end else begin
            unique case (st_q)
                S_DEV, S_WORD, S_WDAT: begin
                    if (scl_rise) begin
                        rx_q  <= {rx_q[6:0], sda_bit};
                        cnt_q <= cnt_q + 4'd1;
                    end else if (scl_fall && byte_done) begin
                        if (st_q == S_DEV) begin
                            if (dev_hit && !busy_o) begin
                                sda_oe_q <= 1'b1;
                                rw_q     <= rx_q[0];
                                if (!rx_q[0]) addr_q <= addr_devw;
                            end
                        end else if (st_q == S_WORD) begin
                            addr_q   <= addr_word;
                            sda_oe_q <= 1'b1;
                        end else begin
                            addr_q[OFS_W-1:0] <= addr_q[OFS_W-1:0] + 1'b1;
                            sda_oe_q <= 1'b1;
                        end
                    end
                end
                S_DACK: begin
                    if (scl_fall) begin
                        cnt_q    <= '0;
                        sda_oe_q <= 1'b0;
                        if (rw_q) begin
                            tx_q     <= rd_byte;
                            sda_oe_q <= ~rd_byte[7];
                        end
                    end
                end
                S_WACKA, S_WACK: begin
                    if (scl_fall) begin
                        cnt_q    <= '0;
                        sda_oe_q <= 1'b0;
                    end
                end
                S_RDAT: begin
                    if (scl_rise) begin
                        cnt_q <= cnt_q + 4'd1;
                    end else if (scl_fall) begin
                        if (byte_done) begin
                            sda_oe_q <= 1'b0;
                            addr_q   <= addr_q + 1'b1;
                        end else begin
                            tx_q     <= {tx_q[6:0], 1'b0};
                            sda_oe_q <= ~tx_q[6];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_fall) begin
                        cnt_q    <= '0;
                        tx_q     <= rd_byte;
                        sda_oe_q <= ~rd_byte[7];
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = sda_oe_q;

    // Page buffer control
    assign buf_wr  = (st_q == S_WDAT) && scl_fall && byte_done && !start_det && !stop_det;
    assign commit  = stop_det && buf_any;
    assign buf_clr = start_det || commit;

    eep_page_buf #(.SLOTS(PAGE_BYTES)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (buf_clr),
        .wr_i   (buf_wr),
        .idx_i  (addr_q[OFS_W-1:0]),
        .data_i (rx_q),
        .data_o (buf_data),
        .mask_o (buf_mask),
        .any_o  (buf_any)
    );

    eep_array #(.BYTES(MEM_BYTES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .page_i   (addr_q[AW-1:OFS_W]),
        .wp_i     (wp_i),
        .wdata_i  (buf_data),
        .wmask_i  (buf_mask),
        .raddr_i  (addr_q),
        .rdata_o  (rd_byte)
    );

    eep_wcycle #(.CYCLES(WRITE_CYCLES)) u_wcycle (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit),
        .busy_o  (busy_o)
    );

    // R11: the target never holds SDA low while idle
    p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE) |-> !sda_oe_q);

    // R6: no address acknowledge while the write cycle runs
    p_no_ack_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DACK) |-> !busy_o);

    // R5: storing a data byte never moves the page bits
    p_page_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> (addr_q[AW-1:OFS_W] == $past(addr_q[AW-1:OFS_W])));
endmodule

// File: tb/i2c_eeprom_wp_test.sv
`timescale 1ns/1ps
module i2c_eeprom_wp_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    logic oe_a, oe_b, busy_a, busy_b;
    logic sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int q = 10;
    logic [7:0] wbuf [0:19];
    logic [7:0] rbuf [0:19];
    logic       last_release;

    always #2.5 clk = ~clk;

    assign sda_line = ~(m_low | oe_a | oe_b);

    i2c_eeprom_wp #(.MEM_BYTES(256), .WRITE_CYCLES(1000)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(oe_a), .sel_i(3'b000), .wp_i(wp), .busy_o(busy_a));

    i2c_eeprom_wp #(.MEM_BYTES(512), .WRITE_CYCLES(1000)) uut_blk (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(oe_b), .sel_i(3'b011), .wp_i(wp), .busy_o(busy_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(q);
        scl = 1'b1;   tick(q);
        m_low = 1'b1; tick(q);
        scl = 1'b0;   tick(q);
    endtask

    task automatic bus_stop();
        scl = 1'b0;   m_low = 1'b1; tick(q);
        scl = 1'b1;   tick(q);
        m_low = 1'b0; tick(2*q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; tick(q);
            scl = 1'b1;    tick(2*q);
            scl = 1'b0;    tick(q);
        end
        m_low = 1'b0; tick(q);
        scl = 1'b1;   tick(q);
        ack = ~sda_line;
        tick(q);
        scl = 1'b0;   tick(q);
    endtask

    task automatic recv_byte(input bit do_ack, output logic [7:0] b);
        m_low = 1'b0;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            tick(q);
            scl = 1'b1; tick(q);
            b = {b[6:0], sda_line};
            tick(q);
            scl = 1'b0;
        end
        tick(q);
        m_low = do_ack; tick(q);
        scl = 1'b1;     tick(2*q);
        scl = 1'b0;     tick(q);
        m_low = 1'b0;
    endtask

    task automatic write_page(input logic [6:0] dev, input logic [7:0] a, input int n, output bit all_ack);
        bit ak;
        all_ack = 1'b1;
        bus_start();
        send_byte({dev, 1'b0}, ak); all_ack &= ak;
        send_byte(a, ak);           all_ack &= ak;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ak); all_ack &= ak;
        end
        bus_stop();
    endtask

    task automatic random_read(input logic [6:0] dev, input logic [7:0] a, input int n);
        bit ak;
        logic [7:0] b;
        bus_start();
        send_byte({dev, 1'b0}, ak);
        send_byte(a, ak);
        bus_start();
        send_byte({dev, 1'b1}, ak);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        tick(2);
        last_release = sda_line & ~oe_a & ~oe_b;
        bus_stop();
    endtask

    task automatic current_read(input logic [6:0] dev, output logic [7:0] b);
        bit ak;
        bus_start();
        send_byte({dev, 1'b1}, ak);
        recv_byte(1'b0, b);
        bus_stop();
    endtask

    task automatic wait_ready(input logic [6:0] dev, output bit ready);
        bit ak = 1'b0;
        int polls = 0;
        while (!ak && polls < 30) begin
            bus_start();
            send_byte({dev, 1'b0}, ak);
            bus_stop();
            polls++;
        end
        ready = ak;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        chk("R1 sda released", {31'd0, sda_line}, 32'd1);
        chk("R1 busy low", {30'd0, busy_a, busy_b}, 32'd0);
        current_read(7'h50, b);
        chk("R1 array zero at address 0", {24'd0, b}, 32'h00);
    endtask

    task automatic t_page_write();
        bit ok, ak, rdy;
        logic [7:0] b;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        write_page(7'h50, 8'h20, 4, ok);
        chk("R4 write acked", {31'd0, ok}, 32'd1);
        chk("R6 busy after commit", {31'd0, busy_a}, 32'd1);
        bus_start(); send_byte({7'h50, 1'b0}, ak); bus_stop();
        chk("R6 no ack while busy", {31'd0, ak}, 32'd0);
        wait_ready(7'h50, rdy);
        chk("R6 ack after cycle", {31'd0, rdy}, 32'd1);
        random_read(7'h50, 8'h20, 4);
        chk("R8 random read byte 0", {24'd0, rbuf[0]}, 32'h11);
        chk("R9 sequential byte 1", {24'd0, rbuf[1]}, 32'h22);
        chk("R9 sequential byte 2", {24'd0, rbuf[2]}, 32'h33);
        chk("R9 sequential byte 3", {24'd0, rbuf[3]}, 32'h44);
        current_read(7'h50, b);
        chk("R10 current read continues", {24'd0, b}, 32'h00);
    endtask

    task automatic t_discard();
        bit ak;
        logic [7:0] b;
        bus_start();
        send_byte({7'h50, 1'b0}, ak);
        send_byte(8'h20, ak);
        send_byte(8'hAA, ak);
        bus_start();
        send_byte({7'h50, 1'b0}, ak);
        send_byte(8'h20, ak);
        bus_start();
        send_byte({7'h50, 1'b1}, ak);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R4 discarded byte not stored", {24'd0, b}, 32'h11);
        chk("R4 no write cycle after discard", {31'd0, busy_a}, 32'd0);
    endtask

    task automatic t_wrap();
        bit ok, rdy;
        for (int i = 0; i < 17; i++) wbuf[i] = 8'h40 + 8'(i);
        write_page(7'h50, 8'h30, 17, ok);
        wait_ready(7'h50, rdy);
        random_read(7'h50, 8'h30, 2);
        chk("R5 wrapped byte overwrote slot 0", {24'd0, rbuf[0]}, 32'h50);
        chk("R5 slot 1 kept", {24'd0, rbuf[1]}, 32'h41);
        random_read(7'h50, 8'h40, 1);
        chk("R5 next page untouched", {24'd0, rbuf[0]}, 32'h00);
    endtask

    task automatic t_protect();
        bit ok, rdy;
        wp = 1'b1;
        wbuf[0] = 8'h5A; wbuf[1] = 8'h5B;
        write_page(7'h50, 8'h90, 2, ok);
        chk("R7 protected data acked", {31'd0, ok}, 32'd1);
        wait_ready(7'h50, rdy);
        wbuf[0] = 8'h77;
        write_page(7'h50, 8'h10, 1, ok);
        wait_ready(7'h50, rdy);
        wp = 1'b0;
        random_read(7'h50, 8'h90, 1);
        chk("R7 upper half unchanged", {24'd0, rbuf[0]}, 32'h00);
        random_read(7'h50, 8'h10, 1);
        chk("R7 lower half written", {24'd0, rbuf[0]}, 32'h77);
    endtask

    task automatic t_seq_wrap();
        bit ok, rdy;
        wbuf[0] = 8'hEE;
        write_page(7'h50, 8'hFF, 1, ok);
        wait_ready(7'h50, rdy);
        wbuf[0] = 8'h01;
        write_page(7'h50, 8'h00, 1, ok);
        wait_ready(7'h50, rdy);
        random_read(7'h50, 8'hFF, 2);
        chk("R9 last address", {24'd0, rbuf[0]}, 32'hEE);
        chk("R9 wrap to address 0", {24'd0, rbuf[1]}, 32'h01);
        chk("R11 SDA released after NACK", {31'd0, last_release}, 32'd1);
    endtask

    task automatic t_wrong_addr();
        bit ak;
        bus_start();
        send_byte({7'h51, 1'b0}, ak);
        chk("R2 unmatched address not acked", {31'd0, ak}, 32'd0);
        send_byte(8'h00, ak);
        chk("R2 silent for rest of frame", {31'd0, ak}, 32'd0);
        bus_stop();
    endtask

    task automatic t_block();
        bit ok, rdy;
        wbuf[0] = 8'h99;
        write_page(7'h53, 8'h05, 1, ok);
        chk("R3 block-1 address acked", {31'd0, ok}, 32'd1);
        wait_ready(7'h53, rdy);
        chk("R3 low strap ignored", {31'd0, rdy}, 32'd1);
        random_read(7'h52, 8'h05, 1);
        chk("R3 block 0 distinct", {24'd0, rbuf[0]}, 32'h00);
        random_read(7'h53, 8'h05, 1);
        chk("R3 block 1 stored", {24'd0, rbuf[0]}, 32'h99);
        wp = 1'b1;
        wbuf[0] = 8'h33;
        write_page(7'h52, 8'hF0, 1, ok);
        wait_ready(7'h52, rdy);
        wbuf[0] = 8'h44;
        write_page(7'h53, 8'h10, 1, ok);
        wait_ready(7'h53, rdy);
        wp = 1'b0;
        random_read(7'h52, 8'hF0, 1);
        chk("R7 512 lower half written", {24'd0, rbuf[0]}, 32'h33);
        random_read(7'h53, 8'h10, 1);
        chk("R7 512 upper half blocked", {24'd0, rbuf[0]}, 32'h00);
    endtask

    task automatic t_slow();
        bit ok, rdy;
        q = 40;
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        write_page(7'h50, 8'h60, 2, ok);
        chk("R12 slow write acked", {31'd0, ok}, 32'd1);
        wait_ready(7'h50, rdy);
        random_read(7'h50, 8'h60, 2);
        chk("R12 slow read byte 0", {24'd0, rbuf[0]}, 32'hC3);
        chk("R12 slow read byte 1", {24'd0, rbuf[1]}, 32'h3C);
        q = 10;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (10) @(posedge clk);
        #1 rst_n = 1'b1;
        tick(5);
        t_reset();
        t_page_write();
        t_discard();
        t_wrap();
        t_protect();
        t_seq_wrap();
        t_wrong_addr();
        t_block();
        t_slow();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule